// File: doc/BRIEF.md
# I2S Serial Audio Receiver with Sample FIFO

This block takes a three-wire serial audio stream (bit clock, word select, data) and turns it into parallel samples. The data line is read most significant bit first. Samples are 8, 16 or 32 bits wide, placed at the low end of a 32-bit word, and queued in an eight-entry FIFO. A simple read port pops the FIFO: the head word is always visible, and a one-cycle read strobe removes it. The channel can use the bit clock and word select from another device (slave). It can also generate both itself (master), with a programmable bit-clock divider and a programmable number of bit periods per word-select half.

Firmware or a DMA engine reads the FIFO through the interrupt and DMA request outputs. Each output compares the fill level with its own programmable threshold. In mono mode only the left slot (word select low) is kept. Mute keeps the capture timing but stores zero words. Stop freezes capture and, in master mode, holds the generated clocks. A channel clear empties the FIFO and restarts word alignment. When the FIFO is full, new words are discarded and a sticky overrun flag is raised.

All three serial inputs pass through two-stage synchronizers into the system clock domain. A bit-clock half period must therefore last at least three system clock cycles.

Top module: `i2s_rx`

## Requirements
- R1: After reset `fifo_level`, `irq`, `overrun`, `sck_out` and `ws_out` are 0, and `dma_req` is 0 for every threshold.
- R2: Data is sampled on each rising bit-clock edge. The bit sampled at the first rising edge after a word-select change is the MSB, and later bits follow MSB first. `cfg_width` selects the width: 0 = 8, 1 = 16, 2 or 3 = 32 bits. The sample is right-aligned in `rd_data`, with the bits above the width at zero.
- R3: A slot shorter than the width leaves the missing low bits at zero. Bits of a slot beyond the width are ignored.
- R4: A word is stored at the rising edge where word select is first seen changed; the data bit sampled at that edge is the last bit of the word. Words are stored in arrival order, both slots in stereo. The first change seen after reset, clear or stop only aligns the receiver and stores nothing.
- R5: With `cfg_mono` = 1 only words from slots with word select low are stored.
- R6: With `cfg_mute` = 1 each completed word is still stored, but with value zero.
- R7: The FIFO holds 8 words. `rd_data` shows the oldest word, and `rd_en` for one cycle removes it. `rd_en` with an empty FIFO has no effect.
- R8: A word completed while the FIFO is full is dropped, and `overrun` goes to 1 and stays there until a channel clear.
- R9: `irq` is 1 exactly when `fifo_level` > `cfg_irq_thr`.
- R10: `dma_req` is 1 exactly when `cfg_dma_thr` is non-zero and `fifo_level` >= `cfg_dma_thr`.
- R11: In master mode `sck_out` toggles every `cfg_clk_div`+1 clock cycles. `ws_out` toggles only together with a falling edge of `sck_out`, once every `cfg_slot_len`+1 bit periods.
- R12: While `cfg_stop` = 1 no word is captured, the master outputs hold their values, and the FIFO can still be read.
- R13: A `cfg_clear` pulse empties the FIFO, clears `overrun`, restarts word alignment and returns `sck_out` and `ws_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1: generate bit clock and word select; 0: follow the external ones |
| cfg_width | input | 2 | Sample width code (0 = 8, 1 = 16, 2/3 = 32) |
| cfg_mono | input | 1 | Keep only left-slot words |
| cfg_mute | input | 1 | Store zero words |
| cfg_stop | input | 1 | Freeze capture and master timing |
| cfg_clear | input | 1 | Synchronous channel clear |
| cfg_clk_div | input | DIV_W | Bit-clock half period minus one, in clock cycles |
| cfg_slot_len | input | SLOT_W | Bit periods per word-select half, minus one |
| cfg_irq_thr | input | LVL_W | Interrupt threshold |
| cfg_dma_thr | input | LVL_W | DMA request threshold (0 disables) |
| sck_in | input | 1 | External bit clock (slave mode) |
| ws_in | input | 1 | External word select (slave mode) |
| sd_in | input | 1 | Serial data |
| sck_out | output | 1 | Generated bit clock (master mode) |
| ws_out | output | 1 | Generated word select (master mode) |
| rd_en | input | 1 | Pop the head word |
| rd_data | output | 32 | Head word of the FIFO, zero when empty |
| fifo_level | output | LVL_W | Number of stored words |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |
| overrun | output | 1 | Sticky word-dropped flag |

## Verification
The bench keeps the default parameters: DEPTH = 8, DIV_W = 8 and SLOT_W = 6. The 6-bit slot length allows slots both shorter and longer than every sample width, so zero filling and truncation are both tested in master and slave mode. Dividers from 2 to 5 keep every master bit period inside the synchronizer margin and the run short. The eight-entry depth lets an 11-word burst overflow the FIFO, and every interrupt threshold (0 to 7) and DMA threshold (0 to 8) is reached while the FIFO is drained.

// File: rtl/i2s_rx.sv
module i2s_rx #(
  parameter int DEPTH  = 8,
  parameter int DIV_W  = 8,
  parameter int SLOT_W = 6,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_master,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_mono,
  input  logic              cfg_mute,
  input  logic              cfg_stop,
  input  logic              cfg_clear,
  input  logic [DIV_W-1:0]  cfg_clk_div,
  input  logic [SLOT_W-1:0] cfg_slot_len,
  input  logic [LVL_W-1:0]  cfg_irq_thr,
  input  logic [LVL_W-1:0]  cfg_dma_thr,
  input  logic              sck_in,
  input  logic              ws_in,
  input  logic              sd_in,
  output logic              sck_out,
  output logic              ws_out,
  input  logic              rd_en,
  output logic [31:0]       rd_data,
  output logic [LVL_W-1:0]  fifo_level,
  output logic              irq,
  output logic              dma_req,
  output logic              overrun
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // input synchronizers
  logic [2:0] sck_sy;
  logic [1:0] ws_sy, sd_sy;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_sy <= '0;
      ws_sy  <= '0;
      sd_sy  <= '0;
    end else begin
      sck_sy <= {sck_sy[1:0], sck_in};
      ws_sy  <= {ws_sy[0], ws_in};
      sd_sy  <= {sd_sy[0], sd_in};
    end

  // master timing
  logic [DIV_W-1:0]  div_cnt;
  logic [SLOT_W-1:0] slot_cnt;
  logic              m_sck, m_ws;
  wire m_tick = div_cnt >= cfg_clk_div;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_cnt  <= '0;
      slot_cnt <= '0;
      m_sck    <= 1'b0;
      m_ws     <= 1'b0;
    end else if (cfg_clear || !cfg_master) begin
      div_cnt  <= '0;
      slot_cnt <= '0;
      m_sck    <= 1'b0;
      m_ws     <= 1'b0;
    end else if (!cfg_stop) begin
      if (m_tick) begin
        div_cnt <= '0;
        m_sck   <= !m_sck;
        if (m_sck) begin
          if (slot_cnt >= cfg_slot_len) begin
            slot_cnt <= '0;
            m_ws     <= !m_ws;
          end else begin
            slot_cnt <= slot_cnt + 1'b1;
          end
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end

  assign sck_out = m_sck;
  assign ws_out  = m_ws;

  // bit capture
  wire s_rise = sck_sy[1] & ~sck_sy[2];
  wire bit_ev = !cfg_stop && (cfg_master ? (m_tick && !m_sck) : s_rise);
  wire bit_ws = cfg_master ? m_ws : ws_sy[1];
  wire bit_sd = sd_sy[1];

  logic [5:0] wlen;
  always_comb
    case (cfg_width)
      2'd0:    wlen = 6'd8;
      2'd1:    wlen = 6'd16;
      default: wlen = 6'd32;
    endcase

  logic [31:0] sh, nsh;
  logic [5:0]  bcnt;
  logic        ws_d, aligned;
  wire  [4:0]  pos = 5'(wlen - 6'd1 - bcnt);

  always_comb begin
    nsh = sh;
    if (bcnt < wlen) nsh[pos] = bit_sd;
  end

  wire ws_chg = bit_ws != ws_d;
  wire commit = bit_ev && ws_chg && aligned && !(cfg_mono && ws_d);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh      <= '0;
      bcnt    <= '0;
      ws_d    <= 1'b0;
      aligned <= 1'b0;
    end else if (cfg_clear || cfg_stop) begin
      sh      <= '0;
      bcnt    <= '0;
      ws_d    <= 1'b0;
      aligned <= 1'b0;
    end else if (bit_ev) begin
      if (ws_chg) begin
        sh      <= '0;
        bcnt    <= '0;
        ws_d    <= bit_ws;
        aligned <= 1'b1;
      end else begin
        sh <= nsh;
        if (bcnt < wlen) bcnt <= bcnt + 6'd1;
      end
    end

  // sample FIFO
  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [31:0]      mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  wire full  = fifo_level == LVL_W'(DEPTH);
  wire wr_ok = commit && !full;
  wire rd_ok = rd_en && (fifo_level != '0);

  always_ff @(posedge clk)
    if (wr_ok) mem[wr_ptr] <= cfg_mute ? 32'd0 : nsh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      fifo_level <= '0;
      overrun    <= 1'b0;
    end else if (cfg_clear) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      fifo_level <= '0;
      overrun    <= 1'b0;
    end else begin
      if (wr_ok) wr_ptr <= nxt(wr_ptr);
      if (rd_ok) rd_ptr <= nxt(rd_ptr);
      fifo_level <= fifo_level + LVL_W'(wr_ok) - LVL_W'(rd_ok);
      if (commit && full) overrun <= 1'b1;
    end

  assign rd_data = (fifo_level != '0) ? mem[rd_ptr] : 32'd0;
  assign irq     = fifo_level > cfg_irq_thr;
  assign dma_req = (cfg_dma_thr != '0) && (fifo_level >= cfg_dma_thr);
endmodule

// File: rtl/i2s_rx_chk.sv
module i2s_rx_chk #(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_master,
  input logic             cfg_stop,
  input logic             cfg_clear,
  input logic             sck_out,
  input logic             ws_out,
  input logic [LVL_W-1:0] fifo_level,
  input logic             overrun,
  input logic             wr_ok
);
  AST_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LVL_W'(DEPTH)); // R7

  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_clear) |-> (fifo_level == $past(fifo_level) ||
                           fifo_level == $past(fifo_level) + 1'b1 ||
                           fifo_level == $past(fifo_level) - 1'b1)); // R7

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level == '0 && !wr_ok && !cfg_clear) |=> fifo_level == '0); // R7

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !cfg_clear) |=> overrun); // R8

  AST_OVR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(fifo_level) == LVL_W'(DEPTH)); // R8

  AST_WS_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_master) && !$past(cfg_clear) && ws_out != $past(ws_out)) |-> $fell(sck_out)); // R11

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_master) && $past(cfg_stop) && !$past(cfg_clear)) |-> ($stable(sck_out) && $stable(ws_out))); // R12

  AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clear |=> (fifo_level == '0 && !overrun && !sck_out && !ws_out)); // R13
endmodule

bind i2s_rx i2s_rx_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_stop(cfg_stop),
  .cfg_clear(cfg_clear), .sck_out(sck_out), .ws_out(ws_out),
  .fifo_level(fifo_level), .overrun(overrun), .wr_ok(wr_ok)
);

// File: tb/tb_i2s_rx.sv
module tb_i2s_rx;
  localparam int LVL_W = 4;
  localparam int P = 3;

  logic clk = 0, rst_n = 0;
  logic cfg_master = 0, cfg_mono = 0, cfg_mute = 0, cfg_stop = 0, cfg_clear = 0;
  logic [1:0] cfg_width = 0;
  logic [7:0] cfg_clk_div = 3;
  logic [5:0] cfg_slot_len = 15;
  logic [LVL_W-1:0] cfg_irq_thr = 0, cfg_dma_thr = 1;
  logic sck_in = 1, ws_in = 0, s_sd = 0, m_sd = 0;
  logic rd_en = 0;
  wire sd_in = cfg_master ? m_sd : s_sd;
  wire sck_out, ws_out, irq, dma_req, overrun;
  wire [31:0] rd_data;
  wire [LVL_W-1:0] fifo_level;

  i2s_rx dut (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_width(cfg_width),
    .cfg_mono(cfg_mono), .cfg_mute(cfg_mute), .cfg_stop(cfg_stop), .cfg_clear(cfg_clear),
    .cfg_clk_div(cfg_clk_div), .cfg_slot_len(cfg_slot_len), .cfg_irq_thr(cfg_irq_thr),
    .cfg_dma_thr(cfg_dma_thr), .sck_in(sck_in), .ws_in(ws_in), .sd_in(sd_in),
    .sck_out(sck_out), .ws_out(ws_out), .rd_en(rd_en), .rd_data(rd_data),
    .fifo_level(fifo_level), .irq(irq), .dma_req(dma_req), .overrun(overrun)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_err = 0;
  logic [31:0] exp_q[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int wbits(input logic [1:0] code);
    return (code == 0) ? 8 : (code == 1) ? 16 : 32;
  endfunction

  function automatic logic [31:0] exp_word(input logic [31:0] d, input int s, input int w, input bit mute);
    logic [31:0] v;
    if (mute) return 32'd0;
    v = d >> (32 - w);
    if (s < w) v = v & ~((32'd1 << (w - s)) - 32'd1);
    return v;
  endfunction

  // master-mode serial source, reacts to the generated clocks
  bit m_en = 0;
  logic m_psck = 0, m_pws = 0;
  int m_n = -1, m_j = 0, m_tog = 0, hp_cnt = 0, hp_meas = 0, sl_cnt = 0, sl_meas = 0, m_s = 16;
  logic [31:0] m_data [32];

  always @(negedge clk) begin
    if (!m_en) begin
      m_psck = 0; m_pws = 0; m_n = -1; m_j = 0; m_tog = 0;
      hp_cnt = 0; hp_meas = 0; sl_cnt = 0; sl_meas = 0; m_sd = 0;
    end else begin
      hp_cnt++;
      if (sck_out != m_psck) begin
        hp_meas = hp_cnt;
        hp_cnt = 0;
        if (m_psck && !sck_out) begin
          sl_cnt++;
          if (ws_out != m_pws) begin
            m_sd = (m_n >= 0) ? m_data[m_n][32 - m_s] : 1'b0;
            if (m_tog >= 1) sl_meas = sl_cnt;
            sl_cnt = 0;
            if (m_n < 31) m_n++;
            m_data[m_n] = $urandom;
            m_j = 1;
            m_tog++;
          end else begin
            m_sd = (m_n >= 0) ? m_data[m_n][32 - m_j] : 1'b0;
            m_j++;
          end
        end
      end
      m_psck = sck_out;
      m_pws = ws_out;
    end
  end

  task automatic chan_clear();
    @(negedge clk) cfg_clear = 1;
    @(negedge clk) cfg_clear = 0;
  endtask

  task automatic slave_bit(input logic ws, input logic sd);
    @(negedge clk);
    sck_in = 0; ws_in = ws; s_sd = sd;
    repeat (P) @(negedge clk);
    sck_in = 1;
    repeat (P - 1) @(negedge clk);
  endtask

  task automatic slave_stream(input int nsl, input int s, input int w, input bit mono, input bit mute);
    logic prev = 0;
    logic ws = 1;
    logic [31:0] d;
    for (int n = 0; n < nsl; n++) begin
      d = $urandom;
      if (!mono || ws == 0) exp_q.push_back(exp_word(d, s, w, mute));
      for (int i = 0; i < s; i++) begin
        slave_bit(ws, prev);
        prev = d[31 - i];
      end
      ws = ~ws;
    end
    slave_bit(ws, prev);
    repeat (6) @(negedge clk);
  endtask

  task automatic drain(input string req);
    int lvl;
    #1;
    lvl = (exp_q.size() > 8) ? 8 : exp_q.size();
    chk({req, " R7 level"}, 32'(fifo_level), 32'(lvl));
    while (lvl > 0) begin
      chk("R9 irq", 32'(irq), 32'(lvl > int'(cfg_irq_thr)));
      chk("R10 dma_req", 32'(dma_req), 32'(cfg_dma_thr != 0 && lvl >= int'(cfg_dma_thr)));
      chk({req, " data"}, rd_data, exp_q.pop_front());
      @(negedge clk) rd_en = 1;
      @(negedge clk) rd_en = 0;
      #1;
      lvl--;
    end
    chk("R7 empty after drain", 32'(fifo_level), 32'd0);
    chk("R10 dma_req empty", 32'(dma_req), 32'd0);
    exp_q.delete();
  endtask

  task automatic slave_trial(input logic [1:0] code, input int s, input int nsl, input bit mono, input bit mute, input string req);
    cfg_master = 0; cfg_width = code; cfg_mono = mono; cfg_mute = mute;
    chan_clear();
    slave_stream(nsl, s, wbits(code), mono, mute);
    drain(req);
  endtask

  task automatic master_trial(input int div, input int s, input logic [1:0] code, input bit mono, input bit mute, input int nw);
    logic so, wo;
    logic [LVL_W-1:0] lv;
    m_en = 0;
    cfg_master = 1; cfg_stop = 0; cfg_clk_div = 8'(div); cfg_slot_len = 6'(s - 1);
    cfg_width = code; cfg_mono = mono; cfg_mute = mute; m_s = s;
    chan_clear();
    m_en = 1;
    while (m_tog < nw + 1) @(negedge clk);
    repeat (div + 4) @(negedge clk);
    cfg_stop = 1;
    for (int n = 0; n < nw; n++)
      if (!mono || n % 2 == 1) exp_q.push_back(exp_word(m_data[n], s, wbits(code), mute));
    chk("R11 sck half period", 32'(hp_meas), 32'(div + 1));
    chk("R11 ws slot length", 32'(sl_meas), 32'(s));
    @(negedge clk);
    so = sck_out; wo = ws_out; lv = fifo_level;
    repeat (4 * (div + 1)) @(negedge clk);
    chk("R12 sck held", 32'(sck_out), 32'(so));
    chk("R12 ws held", 32'(ws_out), 32'(wo));
    chk("R12 level held", 32'(fifo_level), 32'(lv));
    drain("R2/R4 master");
    m_en = 0;
    cfg_stop = 0;
    cfg_master = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h51A7));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 level", 32'(fifo_level), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 dma_req", 32'(dma_req), 0);
    chk("R1 overrun", 32'(overrun), 0);
    chk("R1 sck_out", 32'(sck_out), 0);
    chk("R1 ws_out", 32'(ws_out), 0);

    // R7: reading an empty FIFO
    repeat (3) begin @(negedge clk) rd_en = 1; end
    @(negedge clk) rd_en = 0;
    #1 chk("R7 empty read level", 32'(fifo_level), 0);

    // directed widths and slot lengths
    slave_trial(2'd1, 16, 4, 0, 0, "R2 16b stereo");
    slave_trial(2'd1, 4, 3, 0, 0, "R3 zero fill");
    slave_trial(2'd0, 32, 3, 0, 0, "R3 truncate");
    slave_trial(2'd2, 32, 2, 0, 0, "R2 32b");
    slave_trial(2'd0, 8, 6, 1, 0, "R5 mono");
    slave_trial(2'd1, 16, 3, 0, 1, "R6 mute");

    // R8 overrun and R13 clear
    cfg_master = 0; cfg_width = 2; cfg_mono = 0; cfg_mute = 0;
    chan_clear();
    slave_stream(11, 32, 32, 0, 0);
    while (exp_q.size() > 8) void'(exp_q.pop_back());
    #1 chk("R8 overrun set", 32'(overrun), 1);
    drain("R8 kept words");
    chk("R8 overrun sticky", 32'(overrun), 1);
    chan_clear();
    #1 chk("R13 overrun cleared", 32'(overrun), 0);
    chk("R13 level cleared", 32'(fifo_level), 0);

    // R12 slave stop
    cfg_stop = 1;
    slave_stream(4, 8, 8, 0, 0);
    exp_q.delete();
    #1 chk("R12 no capture while stopped", 32'(fifo_level), 0);
    cfg_stop = 0;

    // master mode
    master_trial(2, 16, 2'd1, 0, 0, 4);
    master_trial(3, 6, 2'd0, 1, 0, 6);
    master_trial(5, 24, 2'd2, 0, 1, 3);
    for (int t = 0; t < 3; t++)
      master_trial(2 + $urandom % 4, 4 + $urandom % 29, 2'($urandom % 3), 1'($urandom % 2), 1'($urandom % 4 == 0), 2 + $urandom % 5);

    // constrained random slave traffic
    for (int t = 0; t < 12; t++) begin
      bit mono;
      mono = 1'($urandom % 2);
      cfg_irq_thr = LVL_W'($urandom % 8);
      cfg_dma_thr = LVL_W'($urandom % 9);
      slave_trial(2'($urandom % 4), 4 + $urandom % 29, mono ? 2 + $urandom % 14 : 1 + $urandom % 8,
                  mono, 1'($urandom % 4 == 0), "R2/R4 random");
    end
    finish_run();
  end
endmodule